// File: doc/BRIEF.md
# Address Watchpoint and Retired-PC Sampler

This debug block watches the core for addresses that a debugger cares about. It holds a parameterised number of comparator sets (two by default). Each set has a compare address, a mask that says how many low address bits take no part in the compare, and a function code. The function code chooses what the set watches: the PC of retiring instructions, data reads, data writes, or data accesses of either kind. When an access or retired PC falls inside the masked window, the set raises a one-cycle event on its match output. It also sets a sticky flag, which stays up until the debugger reads the set's function register.

The block also records the PC of the most recently retired instruction in a sample register. It records every retired instruction, including those whose condition check failed. A debugger can read this register at any moment to profile code. Nothing on the core side is stalled or halted.

Register word addresses are made of a select field `reg_addr[3:2]` and a field index `reg_addr[1:0]`. Select 0, index 0 is the PC sample. Select k+1 is comparator set k. In that set, index 0 is the compare address, index 1 is the mask, and index 2 is the function register. Reads are combinational from `reg_addr`. Read side effects take place at the clock edge while `reg_rd` is high.

Top module: `watch_unit`

## Requirements
- R1: Each comparator set k (0 or 1) has a compare address at word `4*(k+1)`, a mask at `4*(k+1)+1` (bits [4:0]) and a function register at `4*(k+1)+2` (bits [2:0]). All of them read back what was last written, and all reset to 0.
- R2: Function code 1 matches only retired PCs. Codes 2, 3 and 4 match only data accesses, never retired PCs.
- R3: With code 1, a retirement whose PC equals the compare address raises the match, whatever the value of `ret_cond_pass`.
- R4: Code 2 matches data reads only (`dacc_write`=0). Code 3 matches data writes only (`dacc_write`=1). Code 4 matches both.
- R5: A mask value m excludes address bits [m-1:0] from the compare. m=0 compares all 32 bits, and m=31 compares only bit 31.
- R6: `match_o[k]` is high for exactly the one cycle after the clock edge at which the matching input was presented.
- R7: A match sets a sticky flag at bit 8 of the set's function register. The flag clears at a clock edge where that function register is read. If a match and the clearing read happen at the same edge, the flag stays set.
- R8: Function code 0, or any code from 5 to 7, never asserts `match_o[k]`, whatever address is presented.
- R9: The PC sample register (word 0) holds the PC of the latest retirement. This includes retirements with `ret_cond_pass`=0. It is updated at the edge where `ret_valid` is high.
- R10: After reset, and until the first retirement, the PC sample register reads 0xFFFFFFFF.
- R11: Writes to word 0 have no effect on the PC sample register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | 32 | PC of the retiring instruction |
| ret_cond_pass | input | 1 | Retiring instruction passed its condition check |
| dacc_valid | input | 1 | A data access occurs this cycle |
| dacc_addr | input | 32 | Data access address |
| dacc_write | input | 1 | 1 for a write access, 0 for a read |
| match_o | output | 2 | One-cycle match event per comparator set |

## Verification
The hardest case to reach is a match and a clearing read of the same function register landing on one clock edge, because both the bus side and the core side have to act in a single cycle. The bench raises the read strobe and a matching data access on the same falling edge. It then reads the register again to confirm the flag survived. Masking at its limits is reached by programming mask 31 and presenting addresses that differ from the compare value everywhere except in the top bit.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [2:0] {
        FN_OFF = 3'd0,
        FN_PC  = 3'd1,
        FN_RD  = 3'd2,
        FN_WR  = 3'd3,
        FN_RW  = 3'd4
    } wp_fn_e;

    localparam int FLD_ADDR = 0;
    localparam int FLD_MASK = 1;
    localparam int FLD_FN   = 2;
    localparam int HIT_BIT  = 8;
endpackage

// File: rtl/wp_comparator.sv
module wp_comparator
    import wp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              fn_read,
    input  logic              ret_valid,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic              dacc_valid,
    input  logic [ADDR_W-1:0] dacc_addr,
    input  logic              dacc_write,
    output logic              match,
    output logic              hit,
    output logic [ADDR_W-1:0] cmp_addr,
    output logic [MASK_W-1:0] cmp_mask,
    output logic [2:0]        cmp_fn
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [MASK_W-1:0] mask;
        logic [2:0]        fn;
        logic              hit;
        logic              match;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic [ADDR_W-1:0] care;
    logic pc_eq, da_eq, fire;

    always_comb begin
        st_d  = st_q;
        care  = {ADDR_W{1'b1}} << st_q.mask;
        pc_eq = ((ret_pc ^ st_q.addr) & care) == '0;
        da_eq = ((dacc_addr ^ st_q.addr) & care) == '0;
        case (st_q.fn)
            FN_PC:   fire = ret_valid & pc_eq;
            FN_RD:   fire = dacc_valid & ~dacc_write & da_eq;
            FN_WR:   fire = dacc_valid & dacc_write & da_eq;
            FN_RW:   fire = dacc_valid & da_eq;
            default: fire = 1'b0;
        endcase
        st_d.match = fire;
        if (fn_read) st_d.hit = 1'b0;
        if (fire)    st_d.hit = 1'b1;
        if (cfg_we) begin
            case (int'(cfg_field))
                FLD_ADDR: st_d.addr = cfg_wdata;
                FLD_MASK: st_d.mask = cfg_wdata[MASK_W-1:0];
                FLD_FN:   st_d.fn   = cfg_wdata[2:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match    = st_q.match;
    assign hit      = st_q.hit;
    assign cmp_addr = st_q.addr;
    assign cmp_mask = st_q.mask;
    assign cmp_fn   = st_q.fn;
endmodule

// File: rtl/wp_pc_sampler.sv
module wp_pc_sampler #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic [ADDR_W-1:0] ret_pc,
    output logic [ADDR_W-1:0] sample
);
    logic [ADDR_W-1:0] pcs_d, pcs_q;

    always_comb begin
        pcs_d = pcs_q;
        if (ret_valid) pcs_d = ret_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcs_q <= '1;
        else        pcs_q <= pcs_d;
    end

    assign sample = pcs_q;
endmodule

// File: rtl/watch_unit.sv
module watch_unit
    import wp_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int ADDR_W   = 32,
    parameter int MASK_W   = 5,
    localparam int SEL_W   = $clog2(NUM_SETS + 1),
    localparam int REG_AW  = SEL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              ret_valid,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic              ret_cond_pass,
    input  logic              dacc_valid,
    input  logic [ADDR_W-1:0] dacc_addr,
    input  logic              dacc_write,
    output logic [NUM_SETS-1:0] match_o
);
    logic [SEL_W-1:0] sel;
    logic [1:0]       fld;
    logic [ADDR_W-1:0] pc_sample;
    logic [NUM_SETS-1:0] hit_flag;
    logic [NUM_SETS-1:0][2:0]        cfg_fn;
    logic [NUM_SETS-1:0][ADDR_W-1:0] cfg_addr;
    logic [NUM_SETS-1:0][MASK_W-1:0] cfg_mask;

    assign sel = reg_addr[REG_AW-1:2];
    assign fld = reg_addr[1:0];

    wp_pc_sampler #(.ADDR_W(ADDR_W)) u_pcs (
        .clk(clk), .rst_n(rst_n),
        .ret_valid(ret_valid), .ret_pc(ret_pc),
        .sample(pc_sample)
    );

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
        logic hit_sel;
        assign hit_sel = (sel == SEL_W'(k + 1));
        wp_comparator #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_cmp (
            .clk(clk), .rst_n(rst_n),
            .cfg_we(reg_wr & hit_sel),
            .cfg_field(fld),
            .cfg_wdata(reg_wdata),
            .fn_read(reg_rd & hit_sel & (fld == 2'(FLD_FN))),
            .ret_valid(ret_valid), .ret_pc(ret_pc),
            .dacc_valid(dacc_valid), .dacc_addr(dacc_addr),
            .dacc_write(dacc_write),
            .match(match_o[k]),
            .hit(hit_flag[k]),
            .cmp_addr(cfg_addr[k]),
            .cmp_mask(cfg_mask[k]),
            .cmp_fn(cfg_fn[k])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (sel == '0 && fld == 2'd0) reg_rdata = pc_sample;
        for (int k = 0; k < NUM_SETS; k++) begin
            if (sel == SEL_W'(k + 1)) begin
                case (int'(fld))
                    FLD_ADDR: reg_rdata = cfg_addr[k];
                    FLD_MASK: reg_rdata = ADDR_W'(cfg_mask[k]);
                    FLD_FN: begin
                        reg_rdata          = ADDR_W'(cfg_fn[k]);
                        reg_rdata[HIT_BIT] = hit_flag[k];
                    end
                    default: reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/watch_unit_chk.sv
module watch_unit_chk #(
    parameter int NUM_SETS = 2,
    parameter int ADDR_W   = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ret_valid,
    input logic [ADDR_W-1:0]        ret_pc,
    input logic                     dacc_valid,
    input logic [NUM_SETS-1:0]      match_o,
    input logic [ADDR_W-1:0]        pc_sample,
    input logic [NUM_SETS-1:0][2:0] cfg_fn,
    input logic [NUM_SETS-1:0]      hit_flag
);
    AST_PCS_FOLLOWS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> pc_sample == $past(ret_pc)); // R9

    AST_PCS_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |=> $stable(pc_sample)); // R10

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_chk
        AST_OFF_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_fn[k] inside {3'd1, 3'd2, 3'd3, 3'd4}) |=> !match_o[k]); // R8

        AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[k] |-> hit_flag[k]); // R7

        AST_MATCH_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            !(ret_valid || dacc_valid) |=> !match_o[k]); // R6
    end
endmodule

bind watch_unit watch_unit_chk #(.NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .ret_valid(ret_valid), .ret_pc(ret_pc),
    .dacc_valid(dacc_valid),
    .match_o(match_o),
    .pc_sample(pc_sample),
    .cfg_fn(cfg_fn),
    .hit_flag(hit_flag)
);

// File: tb/watch_unit_tb.sv
module watch_unit_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ret_valid = 0, ret_cond_pass = 1;
    logic [31:0] ret_pc = '0;
    logic        dacc_valid = 0, dacc_write = 0;
    logic [31:0] dacc_addr = '0;
    logic [1:0]  match_o;

    int n_tests = 0, n_fail = 0;

    always #10 clk = ~clk;

    watch_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_cond_pass(ret_cond_pass),
        .dacc_valid(dacc_valid), .dacc_addr(dacc_addr), .dacc_write(dacc_write),
        .match_o(match_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    // present one data access, return match_o seen after the edge; confirm it drops next cycle (R6)
    task automatic dacc(input logic [31:0] a, input bit w, output logic [1:0] m);
        @(negedge clk);
        dacc_valid = 1; dacc_addr = a; dacc_write = w;
        @(negedge clk);
        m = match_o;
        dacc_valid = 0;
        @(negedge clk);
        chk(match_o == 2'b00, "R6 pulse ends", 32'(match_o), 0);
    endtask

    task automatic retire(input logic [31:0] pc, input bit pass, output logic [1:0] m);
        @(negedge clk);
        ret_valid = 1; ret_pc = pc; ret_cond_pass = pass;
        @(negedge clk);
        m = match_o;
        ret_valid = 0;
        @(negedge clk);
        chk(match_o == 2'b00, "R6 pulse ends", 32'(match_o), 0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(match_o == 2'b00, "R6 reset match", 32'(match_o), 0);
        rd(4'd0, d); chk(d == 32'hFFFF_FFFF, "R10 sample after reset", d, 32'hFFFF_FFFF);
        rd(4'd4, d); chk(d == 0, "R1 reset addr0", d, 0);
        rd(4'd10, d); chk(d == 0, "R1 reset fn1", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(4'd4, 32'hDEAD_BEE0); rd(4'd4, d); chk(d == 32'hDEAD_BEE0, "R1 addr0", d, 32'hDEAD_BEE0);
        wr(4'd9, 32'h0000_0013); rd(4'd9, d); chk(d == 32'h13, "R1 mask1", d, 32'h13);
        wr(4'd9, 32'h0);
        wr(4'd0, 32'h1234_5678); rd(4'd0, d); chk(d == 32'hFFFF_FFFF, "R11 sample write ignored", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_pc_match();
        logic [1:0] m;
        logic [31:0] d;
        wr(4'd4, 32'h1000); wr(4'd5, 0); wr(4'd6, 1);
        retire(32'h1000, 1'b0, m); chk(m == 2'b01, "R3 PC match cond fail", 32'(m), 1);
        retire(32'h1000, 1'b1, m); chk(m == 2'b01, "R3 PC match cond pass", 32'(m), 1);
        retire(32'h1004, 1'b1, m); chk(m == 2'b00, "R3 PC miss", 32'(m), 0);
        dacc(32'h1000, 1'b0, m); chk(m == 2'b00, "R2 PC mode ignores data", 32'(m), 0);
        rd(4'd6, d);
    endtask

    task automatic t_data();
        logic [1:0] m;
        logic [31:0] d;
        wr(4'd8, 32'h2000);
        wr(4'd10, 2);
        dacc(32'h2000, 1'b0, m); chk(m == 2'b10, "R4 read code rd", 32'(m), 2);
        dacc(32'h2000, 1'b1, m); chk(m == 2'b00, "R4 read code wr", 32'(m), 0);
        retire(32'h2000, 1'b1, m); chk(m == 2'b00, "R2 data mode ignores PC", 32'(m), 0);
        wr(4'd10, 3);
        dacc(32'h2000, 1'b0, m); chk(m == 2'b00, "R4 write code rd", 32'(m), 0);
        dacc(32'h2000, 1'b1, m); chk(m == 2'b10, "R4 write code wr", 32'(m), 2);
        wr(4'd10, 4);
        dacc(32'h2000, 1'b0, m); chk(m == 2'b10, "R4 rw code rd", 32'(m), 2);
        dacc(32'h2000, 1'b1, m); chk(m == 2'b10, "R4 rw code wr", 32'(m), 2);
        wr(4'd10, 0);
        rd(4'd10, d);
    endtask

    task automatic t_mask();
        logic [1:0] m;
        logic [31:0] d;
        wr(4'd4, 32'h3000); wr(4'd5, 4); wr(4'd6, 4);
        dacc(32'h300F, 1'b0, m); chk(m == 2'b01, "R5 mask4 inside", 32'(m), 1);
        dacc(32'h3010, 1'b0, m); chk(m == 2'b00, "R5 mask4 outside", 32'(m), 0);
        wr(4'd5, 0);
        dacc(32'h3001, 1'b0, m); chk(m == 2'b00, "R5 mask0 exact", 32'(m), 0);
        wr(4'd4, 32'h8000_0000); wr(4'd5, 31);
        dacc(32'hFFFF_FFFF, 1'b1, m); chk(m == 2'b01, "R5 mask31 top set", 32'(m), 1);
        dacc(32'h7FFF_FFFF, 1'b1, m); chk(m == 2'b00, "R5 mask31 top clear", 32'(m), 0);
        wr(4'd5, 0);
        rd(4'd6, d);
    endtask

    task automatic t_sticky();
        logic [1:0] m;
        logic [31:0] d;
        wr(4'd4, 32'h4000); wr(4'd6, 4);
        rd(4'd6, d); chk(d[8] == 1'b0, "R7 flag clear", d, 32'h4);
        dacc(32'h4000, 1'b0, m);
        rd(4'd6, d); chk(d == 32'h104, "R7 flag set", d, 32'h104);
        rd(4'd6, d); chk(d == 32'h4, "R7 flag cleared by read", d, 32'h4);
        @(negedge clk);
        reg_addr = 4'd6; reg_rd = 1;
        dacc_valid = 1; dacc_addr = 32'h4000; dacc_write = 0;
        @(negedge clk);
        reg_rd = 0; dacc_valid = 0;
        rd(4'd6, d); chk(d == 32'h104, "R7 set beats clear", d, 32'h104);
    endtask

    task automatic t_disabled();
        logic [1:0] m;
        logic [31:0] d;
        wr(4'd4, 32'h5000); wr(4'd5, 0);
        foreach (d[i]) begin end
        wr(4'd6, 0);
        dacc(32'h5000, 1'b0, m); chk(m == 2'b00, "R8 code0 data", 32'(m), 0);
        retire(32'h5000, 1'b1, m); chk(m == 2'b00, "R8 code0 pc", 32'(m), 0);
        for (int c = 5; c < 8; c++) begin
            wr(4'd6, 32'(c));
            dacc(32'h5000, 1'b1, m); chk(m == 2'b00, "R8 reserved code data", 32'(m), 0);
            retire(32'h5000, 1'b1, m); chk(m == 2'b00, "R8 reserved code pc", 32'(m), 0);
        end
        rd(4'd6, d); chk(d[8] == 1'b0, "R8 no flag when off", d, 32'h7);
    endtask

    task automatic t_sample();
        logic [31:0] d;
        @(negedge clk);
        ret_valid = 1; ret_pc = 32'hA000; ret_cond_pass = 1;
        @(negedge clk);
        ret_pc = 32'hA004; ret_cond_pass = 0;
        @(negedge clk);
        ret_valid = 0;
        rd(4'd0, d); chk(d == 32'hA004, "R9 sample cond fail", d, 32'hA004);
        @(negedge clk);
        ret_valid = 1; ret_pc = 32'hB008; ret_cond_pass = 1;
        @(negedge clk);
        ret_valid = 0;
        rd(4'd0, d); chk(d == 32'hB008, "R9 sample latest", d, 32'hB008);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regs();
        t_sample();
        t_pc_match();
        t_data();
        t_mask();
        t_sticky();
        t_disabled();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule